// File: doc/BRIEF.md
# Illegal Condition Reset Detector

This block sits beside a small processor core and watches three kinds of event: instruction fetches, working-register traffic, and program-counter reloads. When any of them shows an illegal condition, it raises a device reset request for one clock. It also reports a 2-bit code that says which source caused the request. The three sources are:

- a fetched instruction word whose tag byte carries the reserved illegal value;
- use of a working register as an address pointer before anything has written that register since the last reset;
- a reload of the program counter whose target falls inside a protected address window. The reload may come from a branch, call, jump or return, or from loading an interrupt or trap vector.

All three sources map onto one shared "illegal condition" reset cause. The 2-bit code lets the rest of the reset logic tell the sources apart. The code also sets the common status bit that software reads after the reset.

After the block has requested a reset, it stays quiet until the device reset input clears it. The same reset returns every working register except the stack pointer to the "never written" state. Window bounds, address and instruction widths, register count, stack-pointer index and the number of pointer-use ports are all parameters.

Top module: `illegal_cond_reset`

## Requirements
- R1: When `fetch_valid_i` is high and bits [23:16] of `fetch_word_i` equal 8'h3F, `rst_req_o` is high in the next cycle with `cause_o` = 2'b01. A word with that tag and `fetch_valid_i` low raises nothing, and neither does any other tag value.
- R2: After reset, registers 0 to 14 are unwritten. A pointer-use event on any port that names an unwritten register raises `rst_req_o` in the next cycle with `cause_o` = 2'b10.
- R3: A write with `wr_en_i` marks register `wr_idx_i` as written from the next cycle on. A pointer use in the same cycle as the write to that register also counts as initialized.
- R4: Register 15, the stack pointer, always counts as initialized, so pointer use of it never raises a request.
- R5: A program-counter reload (`pc_load_i`) whose target lies inside an enabled window raises `rst_req_o` in the next cycle with `cause_o` = 2'b11. The windows are [0x000200, 0x0003FF] and [0x001000, 0x0017FF], bounds included. Both windows apply to branches (`pc_kind_i` = 0) and to vectors (`pc_kind_i` = 1). Any target outside the windows raises nothing.
- R6: When several sources fire in the same cycle, the reported cause follows a fixed priority: opcode first, then pointer, then security.
- R7: `rst_req_o` is high for exactly one cycle. After it, no further request is raised until `rst_i` is asserted. `cause_o` is 2'b00 whenever `rst_req_o` is low.
- R8: While `rst_i` is high, `rst_req_o` is low and `cause_o` is 2'b00. Reset clears every written mark except the stack pointer's and re-arms the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous device reset, active high |
| fetch_valid_i | input | 1 | Fetched word is valid this cycle |
| fetch_word_i | input | 24 | Fetched instruction word |
| wr_en_i | input | 1 | Working-register write strobe |
| wr_idx_i | input | 4 | Index of the register written |
| ptr_use_i | input | 2 | Per-port pointer-use strobe |
| ptr_idx_i | input | 8 | Register index per port, port p in bits [4p+3:4p] |
| pc_load_i | input | 1 | Program counter is being reloaded |
| pc_kind_i | input | 1 | 0 = branch-type change, 1 = interrupt/trap vector |
| pc_target_i | input | 24 | Reload target address |
| rst_req_o | output | 1 | One-cycle reset request |
| cause_o | output | 2 | 00 none, 01 opcode, 10 unwritten pointer, 11 security |

## Verification
Directed cases come first.

- The opcode source is tried with the illegal tag while the fetch is invalid and with neighbouring tag values. This separates a tag compare from a plain strobe.
- Pointer use is tried before a write, after a write and in the same cycle as the write, on both ports and on the stack pointer. This separates a correctly timed written-mark from a lagging or missing one.
- Reload targets are placed on and just outside each window bound, for both kinds of reload. This exposes off-by-one window edges and a guard that covers only one kind.
- Simultaneous sources check the priority, and back-to-back illegal events check that only one request is raised per reset.

Seeded random traffic then mixes all sources with occasional resets against a bench model of the written marks and the request latch.

// File: rtl/icr_pkg.sv
package icr_pkg;

   typedef enum logic [1:0] {
      ICR_NONE     = 2'b00,
      ICR_OPCODE   = 2'b01,
      ICR_POINTER  = 2'b10,
      ICR_SECURITY = 2'b11
   } icr_cause_e;

endpackage

// File: rtl/icr_opcode_check.sv
module icr_opcode_check #(
   parameter int unsigned INSN_W  = 24,
   parameter int unsigned TAG_W   = 8,
   parameter logic [7:0]  TAG_VAL = 8'h3F
) (
   input  logic              valid_i,
   input  logic [INSN_W-1:0] word_i,
   output logic              hit_o
);

   localparam logic [INSN_W-1:0] TAG_MASK = {{TAG_W{1'b1}}, {(INSN_W-TAG_W){1'b0}}};
   localparam logic [INSN_W-1:0] TAG_PAT  =
      {TAG_VAL[TAG_W-1:0], {(INSN_W-TAG_W){1'b0}}};

   if (TAG_W > 8 || TAG_W == 0) begin : g_bad_tag
      $error("icr_opcode_check: TAG_W must lie in 1..8");
   end
   if (TAG_W >= INSN_W) begin : g_bad_insn
      $error("icr_opcode_check: TAG_W must be narrower than INSN_W");
   end

   always_comb begin
      hit_o = valid_i && ((word_i & TAG_MASK) == TAG_PAT);
   end

endmodule

// File: rtl/icr_reg_tracker.sv
module icr_reg_tracker #(
   parameter int unsigned NREG      = 16,
   parameter int unsigned SP_IDX    = 15,
   parameter int unsigned PTR_PORTS = 2,
   localparam int unsigned IDX_W    = $clog2(NREG)
) (
   input  logic                       clk_i,
   input  logic                       rst_i,
   input  logic                       wr_en_i,
   input  logic [IDX_W-1:0]           wr_idx_i,
   input  logic [PTR_PORTS-1:0]       ptr_use_i,
   input  logic [PTR_PORTS*IDX_W-1:0] ptr_idx_i,
   output logic                       hit_o
);

   if ((1 << IDX_W) != NREG) begin : g_bad_nreg
      $error("icr_reg_tracker: NREG must be a power of two");
   end
   if (SP_IDX >= NREG) begin : g_bad_sp
      $error("icr_reg_tracker: SP_IDX out of range");
   end
   if (PTR_PORTS == 0) begin : g_bad_ports
      $error("icr_reg_tracker: need at least one pointer port");
   end

   logic [NREG-1:0]      init_v;
   logic [NREG-1:0]      wr_hot;
   logic [NREG-1:0]      known;
   logic [PTR_PORTS-1:0] miss;

   always_comb begin
      wr_hot = '0;
      if (wr_en_i) wr_hot[wr_idx_i] = 1'b1;
   end

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      if (r == SP_IDX) begin : g_sp
         assign init_v[r] = 1'b1;
      end else begin : g_gp
         logic mark_q;
         always_ff @(posedge clk_i) begin
            if (rst_i)          mark_q <= 1'b0;
            else if (wr_hot[r]) mark_q <= 1'b1;
         end
         assign init_v[r] = mark_q;

         // R3: a write leaves the register marked from the next cycle
         a_r3_write_marks: assert property (@(posedge clk_i) disable iff (rst_i)
            wr_hot[r] |=> init_v[r]);
         // R8: reset clears the mark
         a_r8_reset_clears: assert property (@(posedge clk_i)
            rst_i |=> !init_v[r]);
      end
   end

   assign known = init_v | wr_hot;

   for (genvar p = 0; p < PTR_PORTS; p++) begin : g_port
      assign miss[p] = ptr_use_i[p] && !known[ptr_idx_i[p*IDX_W +: IDX_W]];
   end

   assign hit_o = |miss;

endmodule

// File: rtl/icr_segment_guard.sv
module icr_segment_guard #(
   parameter int unsigned ADDR_W   = 24,
   parameter int unsigned NUM_WIN  = 2,
   parameter logic [NUM_WIN*ADDR_W-1:0] WIN_LO = {24'h001000, 24'h000200},
   parameter logic [NUM_WIN*ADDR_W-1:0] WIN_HI = {24'h0017FF, 24'h0003FF},
   parameter bit GUARD_BRANCH = 1'b1,
   parameter bit GUARD_VECTOR = 1'b1
) (
   input  logic              load_i,
   input  logic              kind_i,
   input  logic [ADDR_W-1:0] target_i,
   output logic              hit_o
);

   if (NUM_WIN == 0) begin : g_bad_count
      $error("icr_segment_guard: need at least one window");
   end

   logic [NUM_WIN-1:0] in_win;
   logic               kind_on;

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      localparam logic [ADDR_W-1:0] LO = WIN_LO[w*ADDR_W +: ADDR_W];
      localparam logic [ADDR_W-1:0] HI = WIN_HI[w*ADDR_W +: ADDR_W];
      if (LO > HI) begin : g_bad_win
         $error("icr_segment_guard: window start above window end");
      end
      if (LO == '0) begin : g_from_zero
         assign in_win[w] = (target_i <= HI);
      end else begin : g_bounded
         assign in_win[w] = (target_i >= LO) && (target_i <= HI);
      end
   end

   if (GUARD_BRANCH && GUARD_VECTOR) begin : g_both
      assign kind_on = kind_i | 1'b1;
   end else if (GUARD_VECTOR) begin : g_vec_only
      assign kind_on = kind_i;
   end else if (GUARD_BRANCH) begin : g_br_only
      assign kind_on = !kind_i;
   end else begin : g_none
      assign kind_on = kind_i & 1'b0;
   end

   assign hit_o = load_i && kind_on && (|in_win);

endmodule

// File: rtl/illegal_cond_reset.sv
module illegal_cond_reset
   import icr_pkg::*;
#(
   parameter int unsigned INSN_W    = 24,
   parameter int unsigned TAG_W     = 8,
   parameter logic [7:0]  TAG_VAL   = 8'h3F,
   parameter int unsigned NREG      = 16,
   parameter int unsigned SP_IDX    = 15,
   parameter int unsigned PTR_PORTS = 2,
   parameter int unsigned ADDR_W    = 24,
   parameter int unsigned NUM_WIN   = 2,
   parameter logic [NUM_WIN*ADDR_W-1:0] WIN_LO = {24'h001000, 24'h000200},
   parameter logic [NUM_WIN*ADDR_W-1:0] WIN_HI = {24'h0017FF, 24'h0003FF},
   parameter bit GUARD_BRANCH = 1'b1,
   parameter bit GUARD_VECTOR = 1'b1,
   localparam int unsigned IDX_W = $clog2(NREG)
) (
   input  logic                       clk_i,
   input  logic                       rst_i,
   input  logic                       fetch_valid_i,
   input  logic [INSN_W-1:0]          fetch_word_i,
   input  logic                       wr_en_i,
   input  logic [IDX_W-1:0]           wr_idx_i,
   input  logic [PTR_PORTS-1:0]       ptr_use_i,
   input  logic [PTR_PORTS*IDX_W-1:0] ptr_idx_i,
   input  logic                       pc_load_i,
   input  logic                       pc_kind_i,
   input  logic [ADDR_W-1:0]          pc_target_i,
   output logic                       rst_req_o,
   output logic [1:0]                 cause_o
);

   logic       opc_hit, ptr_hit, sec_hit;
   icr_cause_e cause_d, cause_q;
   logic       fire, fired_q, req_q;

   icr_opcode_check #(
      .INSN_W (INSN_W),
      .TAG_W  (TAG_W),
      .TAG_VAL(TAG_VAL)
   ) u_opcode (
      .valid_i(fetch_valid_i),
      .word_i (fetch_word_i),
      .hit_o  (opc_hit)
   );

   icr_reg_tracker #(
      .NREG     (NREG),
      .SP_IDX   (SP_IDX),
      .PTR_PORTS(PTR_PORTS)
   ) u_regs (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .wr_en_i  (wr_en_i),
      .wr_idx_i (wr_idx_i),
      .ptr_use_i(ptr_use_i),
      .ptr_idx_i(ptr_idx_i),
      .hit_o    (ptr_hit)
   );

   icr_segment_guard #(
      .ADDR_W      (ADDR_W),
      .NUM_WIN     (NUM_WIN),
      .WIN_LO      (WIN_LO),
      .WIN_HI      (WIN_HI),
      .GUARD_BRANCH(GUARD_BRANCH),
      .GUARD_VECTOR(GUARD_VECTOR)
   ) u_guard (
      .load_i  (pc_load_i),
      .kind_i  (pc_kind_i),
      .target_i(pc_target_i),
      .hit_o   (sec_hit)
   );

   // fixed priority: opcode, then pointer, then security
   always_comb begin
      if (opc_hit)      cause_d = ICR_OPCODE;
      else if (ptr_hit) cause_d = ICR_POINTER;
      else if (sec_hit) cause_d = ICR_SECURITY;
      else              cause_d = ICR_NONE;
   end

   assign fire = (cause_d != ICR_NONE) && !fired_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         req_q   <= 1'b0;
         cause_q <= ICR_NONE;
         fired_q <= 1'b0;
      end else begin
         req_q   <= fire;
         cause_q <= fire ? cause_d : ICR_NONE;
         fired_q <= fired_q | fire;
      end
   end

   assign rst_req_o = req_q;
   assign cause_o   = cause_q;

   // R1: illegal opcode leads to an opcode-cause request
   a_r1_opcode_fires: assert property (@(posedge clk_i) disable iff (rst_i)
      (opc_hit && !fired_q) |=> (rst_req_o && cause_o == 2'b01));
   // R2: unwritten pointer without opcode leads to a pointer-cause request
   a_r2_pointer_fires: assert property (@(posedge clk_i) disable iff (rst_i)
      (ptr_hit && !opc_hit && !fired_q) |=> (rst_req_o && cause_o == 2'b10));
   // R5 / R6: security only when nothing above it fires
   a_r5_security_fires: assert property (@(posedge clk_i) disable iff (rst_i)
      (sec_hit && !opc_hit && !ptr_hit && !fired_q) |=> (rst_req_o && cause_o == 2'b11));
   // R7: exactly one cycle of request
   a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
      rst_req_o |=> !rst_req_o);
   // R7: locked after firing until reset
   a_r7_locked: assert property (@(posedge clk_i) disable iff (rst_i)
      (fired_q && !rst_req_o) |=> !rst_req_o);
   // R7: cause is zero without a request
   a_r7_quiet_cause: assert property (@(posedge clk_i) disable iff (rst_i)
      !rst_req_o |-> (cause_o == 2'b00));
   // R8: reset silences the outputs
   a_r8_reset_quiet: assert property (@(posedge clk_i)
      rst_i |=> (!rst_req_o && cause_o == 2'b00));

endmodule

// File: tb/illegal_cond_reset_test.sv
`timescale 1ns/1ps
module illegal_cond_reset_test;

   logic        clk = 1'b0;
   logic        rst;
   logic        fetch_valid;
   logic [23:0] fetch_word;
   logic        wr_en;
   logic [3:0]  wr_idx;
   logic [1:0]  ptr_use;
   logic [7:0]  ptr_idx;
   logic        pc_load;
   logic        pc_kind;
   logic [23:0] pc_target;
   logic        rst_req;
   logic [1:0]  cause;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [15:0] m_init;
   bit          m_fired;

   always #2 clk = ~clk;

   illegal_cond_reset uut (
      .clk_i(clk), .rst_i(rst),
      .fetch_valid_i(fetch_valid), .fetch_word_i(fetch_word),
      .wr_en_i(wr_en), .wr_idx_i(wr_idx),
      .ptr_use_i(ptr_use), .ptr_idx_i(ptr_idx),
      .pc_load_i(pc_load), .pc_kind_i(pc_kind), .pc_target_i(pc_target),
      .rst_req_o(rst_req), .cause_o(cause)
   );

   function automatic bit in_protected(input logic [23:0] a);
      return (a >= 24'h000200 && a <= 24'h0003FF) ||
             (a >= 24'h001000 && a <= 24'h0017FF);
   endfunction

   function automatic bit reg_known(input logic [3:0] i);
      return (i == 4'd15) || m_init[i] || (wr_en && wr_idx == i);
   endfunction

   function automatic logic [1:0] exp_cause();
      bit o, p, s;
      o = fetch_valid && fetch_word[23:16] == 8'h3F;
      p = (ptr_use[0] && !reg_known(ptr_idx[3:0])) ||
          (ptr_use[1] && !reg_known(ptr_idx[7:4]));
      s = pc_load && in_protected(pc_target);
      if (o) return 2'b01;
      if (p) return 2'b10;
      if (s) return 2'b11;
      return 2'b00;
   endfunction

   task automatic idle();
      rst = 1'b0; fetch_valid = 1'b0; fetch_word = '0;
      wr_en = 1'b0; wr_idx = '0; ptr_use = '0; ptr_idx = '0;
      pc_load = 1'b0; pc_kind = 1'b0; pc_target = '0;
   endtask

   // inputs are set before; applies one edge, compares after it, moves to negedge
   task automatic step(input string tag);
      logic [1:0] ec;
      bit         er;
      ec = exp_cause();
      er = !rst && !m_fired && (ec != 2'b00);
      if (!er) ec = 2'b00;
      @(posedge clk);
      if (rst) begin
         m_init = '0; m_fired = 1'b0;
      end else begin
         if (wr_en) m_init[wr_idx] = 1'b1;
         if (er) m_fired = 1'b1;
      end
      #1;
      checks++;
      if (rst_req !== er || cause !== ec) begin
         errors++;
         $display("FAIL %s: req=%0b cause=%0d expected req=%0b cause=%0d",
                  tag, rst_req, cause, er, ec);
      end
      @(negedge clk);
   endtask

   task automatic do_reset(input string tag);
      idle(); rst = 1'b1; step(tag); idle();
   endtask

   initial begin
      #(4ns * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      m_init = '0; m_fired = 1'b0;
      idle(); rst = 1'b1;
      step("R8 reset state"); step("R8 reset state");
      idle();

      // R1
      fetch_valid = 1; fetch_word = 24'h3F1234; step("R1 illegal tag");
      idle(); step("R7 pulse ends");
      fetch_valid = 1; fetch_word = 24'h3F0000; step("R7 locked after fire");
      do_reset("R8 rearm");
      fetch_valid = 0; fetch_word = 24'h3FFFFF; step("R1 invalid fetch ignored");
      fetch_valid = 1; fetch_word = 24'h3E3F3F; step("R1 neighbour tag 3E");
      fetch_valid = 1; fetch_word = 24'h7F0000; step("R1 neighbour tag 7F");
      idle();

      // R2 / R3 / R4
      ptr_use = 2'b01; ptr_idx = 8'h03; step("R2 unwritten port0");
      do_reset("R8 rearm");
      ptr_use = 2'b10; ptr_idx = 8'h90; step("R2 unwritten port1");
      do_reset("R8 rearm");
      ptr_use = 2'b11; ptr_idx = 8'hFF; step("R4 stack pointer");
      idle(); wr_en = 1; wr_idx = 4'd5; step("R3 write");
      idle(); ptr_use = 2'b01; ptr_idx = 8'h05; step("R3 use after write");
      idle(); wr_en = 1; wr_idx = 4'd6; ptr_use = 2'b10; ptr_idx = 8'h60;
      step("R3 same-cycle write");
      idle(); ptr_use = 2'b11; ptr_idx = 8'h65; step("R3 both written");

      // R5
      idle(); pc_load = 1; pc_target = 24'h0001FF; step("R5 below window0");
      pc_target = 24'h000400; step("R5 above window0");
      pc_target = 24'h000FFF; pc_kind = 1; step("R5 below window1");
      pc_target = 24'h001800; step("R5 above window1");
      pc_load = 0; pc_target = 24'h000300; step("R5 no load ignored");
      pc_load = 1; pc_kind = 0; pc_target = 24'h000200; step("R5 branch low edge");
      do_reset("R8 rearm");
      pc_load = 1; pc_kind = 1; pc_target = 24'h0003FF; step("R5 vector high edge");
      do_reset("R8 rearm");
      pc_load = 1; pc_kind = 1; pc_target = 24'h0017FF; step("R5 vector window1");
      do_reset("R8 rearm");
      pc_load = 1; pc_kind = 0; pc_target = 24'h001000; step("R5 branch window1");
      do_reset("R8 rearm");

      // R6
      fetch_valid = 1; fetch_word = 24'h3F0001; ptr_use = 2'b01; ptr_idx = 8'h02;
      pc_load = 1; pc_target = 24'h000250; step("R6 all three");
      do_reset("R8 rearm");
      ptr_use = 2'b01; ptr_idx = 8'h02; pc_load = 1; pc_target = 24'h000250;
      step("R6 pointer over security");
      do_reset("R8 rearm");

      // R8: marks cleared by reset
      wr_en = 1; wr_idx = 4'd7; step("R8 write before reset");
      do_reset("R8 reset");
      ptr_use = 2'b01; ptr_idx = 8'h07; step("R8 mark cleared");
      do_reset("R8 rearm");

      // seeded random traffic
      void'($urandom(32'h5EED_1234));
      for (int i = 0; i < 4000; i++) begin
         logic [1:0] ec;
         idle();
         rst = (($urandom % 100) < 3) || (m_fired && ($urandom % 2));
         fetch_valid = $urandom % 2;
         fetch_word = $urandom;
         if (($urandom % 10) == 0) fetch_word[23:16] = 8'h3F;
         wr_en = ($urandom % 10) < 4;
         wr_idx = $urandom;
         ptr_use = (($urandom % 10) < 3) ? 2'($urandom) : 2'b00;
         ptr_idx = $urandom;
         pc_load = ($urandom % 10) < 2;
         pc_kind = $urandom;
         case ($urandom % 4)
            0: pc_target = 24'h000200 + 24'($urandom % 512);
            1: pc_target = 24'h001000 + 24'($urandom % 2048);
            default: pc_target = $urandom;
         endcase
         ec = exp_cause();
         case (ec)
            2'b01: step("R1 random");
            2'b10: step("R2 random");
            2'b11: step("R5 random");
            default: step("R7 random quiet");
         endcase
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule